// File: doc/BRIEF.md
# I2C Target with Bus-Commanded Reset

This block is a slave-only I2C target that sits behind two open-drain pads. It samples SCL and SDA with the system clock through synchronisers, recognises START and STOP conditions, and decodes the first byte of each transfer as a 7-bit address plus a direction bit. When the address matches its own, it acknowledges and gives the master access to a byte-wide register file through a simple port: a register pointer, a one-cycle write strobe with address and data, and a combinational read-data input indexed by the pointer.

SDA is only ever pulled low or released; SCL is an input and is never driven. Besides its own address, the target answers the general call address. A reset command sent there produces a one-cycle internal reset pulse for the surrounding logic and returns the block's own pointer to its power-on value, so software on the bus can bring the device back to its reset state without a pin.

Top module: `i2c_target`

## Requirements
- R1: While `rst_n` is low and right after it rises, `sda_oe_o`, `wr_stb_o` and `int_rst_o` are 0 and `rd_addr_o` is 0.
- R2: The block acts on SDA only through `sda_oe_o` (1 = pull low, 0 = release), and `sda_oe_o` changes only while the synchronised SCL is low, except when a START or STOP forces a release.
- R3: SDA falling while SCL is high is a START; it begins reception of an address byte, and a START in the middle of a transfer (repeated START) drops the partial byte so that no write strobe follows from it.
- R4: SDA rising while SCL is high is a STOP; it ends the transfer and releases SDA.
- R5: Bytes are received most significant bit first, sampled on the SCL high pulse; in the address byte bits 7:1 are the address and bit 0 is the direction (1 = read). An address equal to `OWN_ADDR` is acknowledged by pulling SDA low for the whole ninth clock.
- R6: An address byte that matches neither `OWN_ADDR` nor the general call write is not acknowledged, and all further bytes are ignored (no acknowledge, no strobe, pointer unchanged) until the next START or STOP.
- R7: In a write to the own address, the first data byte loads the pointer (`rd_addr_o`); every later byte is acknowledged and gives one `wr_stb_o` pulse with `wr_addr_o` equal to the pointer and `wr_data_o` equal to the byte, after which the pointer increments by one.
- R8: In a read, the byte at `rd_data_i` for the current pointer is sent MSB first (a 1 bit releases SDA, a 0 bit pulls it low) and the pointer increments as each byte is loaded; a master acknowledge (SDA low on the ninth clock) fetches the next byte.
- R9: A master not-acknowledge (SDA high on the ninth clock of a read byte) stops data output; SDA stays released until the next START or STOP.
- R10: The general call is address byte 0x00 and is acknowledged; a following data byte 0x06 is acknowledged, raises `int_rst_o` for exactly one cycle and returns the pointer to 0. Any other byte after a general call, and the byte 0x01 (general call with read direction), get no acknowledge and no reset pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_addr_o | output | PTR_W | Register pointer used for reads |
| rd_data_i | input | 8 | Register value at `rd_addr_o` |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | PTR_W | Register address of the write |
| wr_data_o | output | 8 | Register data of the write |
| int_rst_o | output | 1 | One-cycle reset pulse from the general call command |

## Verification
The general call command byte is the place where two functions meet in one cycle: the eighth rising SCL edge both schedules the acknowledge and clears the pointer while raising the reset pulse. The bench provokes it by leaving the pointer at a non-zero value first, then judges it by the low SDA on the ninth clock, a single reset pulse, and a following read that returns the byte stored at register 0. A repeated START landing mid-byte, while the shift register holds a partial value, is judged by the absence of any write strobe and by the pointer loaded from the next, complete byte.

// File: rtl/i2c_target_pkg.sv
package i2c_target_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WR,
    ST_ACK,
    ST_RD,
    ST_RACK,
    ST_IGN
  } tgt_state_e;

  localparam logic [7:0] GC_ADDR_BYTE = 8'h00;
  localparam logic [7:0] GC_RESET_CMD = 8'h06;

endpackage

// File: rtl/i2c_target_sync.sv
module i2c_target_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_prev;
  logic              sda_prev;

  // bus idles high, so the pipes reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  always_comb begin
    scl_o      = scl_pipe[STAGES-1];
    sda_o      = sda_pipe[STAGES-1];
    scl_rise_o = scl_o & ~scl_prev;
    scl_fall_o = ~scl_o & scl_prev;
    start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
    stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
  end

  AST_COND_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o})); // R3

endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import i2c_target_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h48,
  parameter int         PTR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_stb_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic             int_rst_o
);

  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  tgt_state_e       state_q, state_d;
  logic [2:0]       cnt_q, cnt_d;
  logic [7:0]       sh_q, sh_d;
  logic             oe_q, oe_d;
  logic             drv_q, drv_d;
  logic             gc_q, gc_d;
  logic             first_q, first_d;
  logic             rw_q, rw_d;
  logic             nack_q, nack_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic             stb_q, stb_d;
  logic [PTR_W-1:0] waddr_q, waddr_d;
  logic [7:0]       wdata_q, wdata_d;
  logic             rstp_q, rstp_d;
  logic [7:0]       rx_byte;

  assign rx_byte = {sh_q[6:0], sda_i};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    drv_d   = drv_q;
    gc_d    = gc_q;
    first_d = first_q;
    rw_d    = rw_q;
    nack_d  = nack_q;
    ptr_d   = ptr_q;
    stb_d   = 1'b0;
    waddr_d = waddr_q;
    wdata_d = wdata_q;
    rstp_d  = 1'b0;
    if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = 3'd0;
      oe_d    = 1'b0;
      drv_d   = 1'b0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        ST_ADDR: if (scl_rise_i) begin
          sh_d  = rx_byte;
          cnt_d = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            if (rx_byte[7:1] == OWN_ADDR) begin
              state_d = ST_ACK;
              drv_d   = 1'b1;
              gc_d    = 1'b0;
              rw_d    = rx_byte[0];
              first_d = 1'b1;
            end else if (rx_byte == GC_ADDR_BYTE) begin
              state_d = ST_ACK;
              drv_d   = 1'b1;
              gc_d    = 1'b1;
              rw_d    = 1'b0;
            end else begin
              state_d = ST_IGN;
            end
          end
        end
        ST_WR: if (scl_rise_i) begin
          sh_d  = rx_byte;
          cnt_d = cnt_q + 3'd1;
          if (cnt_q == 3'd7) begin
            state_d = ST_ACK;
            drv_d   = 1'b1;
            if (gc_q) begin
              if (rx_byte == GC_RESET_CMD) begin
                rstp_d = 1'b1;
                ptr_d  = '0;
              end else begin
                state_d = ST_IGN;
                drv_d   = 1'b0;
              end
            end else if (first_q) begin
              ptr_d   = PTR_W'(rx_byte);
              first_d = 1'b0;
            end else begin
              stb_d   = 1'b1;
              waddr_d = ptr_q;
              wdata_d = rx_byte;
              ptr_d   = ptr_q + PTR_ONE;
            end
          end
        end
        ST_ACK: if (scl_fall_i) begin
          if (drv_q) begin
            oe_d  = 1'b1;
            drv_d = 1'b0;
          end else begin
            cnt_d = 3'd0;
            if (rw_q) begin
              state_d = ST_RD;
              sh_d    = rd_data_i;
              oe_d    = ~rd_data_i[7];
              ptr_d   = ptr_q + PTR_ONE;
            end else begin
              state_d = ST_WR;
              oe_d    = 1'b0;
            end
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            cnt_d = cnt_q + 3'd1;
          end else if (scl_fall_i) begin
            if (cnt_q == 3'd0) begin
              state_d = ST_RACK;
              oe_d    = 1'b0;
            end else begin
              sh_d = {sh_q[6:0], 1'b0};
              oe_d = ~sh_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            nack_d = sda_i;
          end else if (scl_fall_i) begin
            if (nack_q) begin
              state_d = ST_IGN;
            end else begin
              state_d = ST_RD;
              sh_d    = rd_data_i;
              oe_d    = ~rd_data_i[7];
              ptr_d   = ptr_q + PTR_ONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 3'd0;
      sh_q    <= 8'h00;
      oe_q    <= 1'b0;
      drv_q   <= 1'b0;
      gc_q    <= 1'b0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      ptr_q   <= '0;
      stb_q   <= 1'b0;
      waddr_q <= '0;
      wdata_q <= 8'h00;
      rstp_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      drv_q   <= drv_d;
      gc_q    <= gc_d;
      first_q <= first_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
      ptr_q   <= ptr_d;
      stb_q   <= stb_d;
      waddr_q <= waddr_d;
      wdata_q <= wdata_d;
      rstp_q  <= rstp_d;
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_o     = ptr_q;
  assign wr_stb_o  = stb_q;
  assign wr_addr_o = waddr_q;
  assign wr_data_o = wdata_q;
  assign int_rst_o = rstp_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> (!$past(scl_i) || $past(start_i) || $past(stop_i))); // R2
  AST_IGN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGN) |-> !oe_q); // R6
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |=> !stb_q); // R7
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rstp_q |=> !rstp_q); // R10
  AST_RST_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !(rstp_q && stb_q)); // R10

endmodule

// File: rtl/i2c_target.sv
module i2c_target #(
  parameter logic [6:0] OWN_ADDR    = 7'h48,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic [PTR_W-1:0] rd_addr_o,
  input  logic [7:0]       rd_data_i,
  output logic             wr_stb_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [7:0]       wr_data_o,
  output logic             int_rst_o
);

  logic scl_s, sda_s, scl_rise, scl_fall, start_c, stop_c;

  i2c_target_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_c),
    .stop_o     (stop_c)
  );

  i2c_target_ctrl #(
    .OWN_ADDR (OWN_ADDR),
    .PTR_W    (PTR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_s),
    .sda_i      (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_c),
    .stop_i     (stop_c),
    .rd_data_i  (rd_data_i),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (rd_addr_o),
    .wr_stb_o   (wr_stb_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .int_rst_o  (int_rst_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!sda_oe_o && !wr_stb_o && !int_rst_o)); // R1

endmodule

// File: tb/i2c_target_tb.sv
`timescale 1ns/1ps
module i2c_target_tb;

  localparam logic [6:0] OWN = 7'h48;
  localparam logic [7:0] AW  = {OWN, 1'b0};
  localparam logic [7:0] AR  = {OWN, 1'b1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic       sda_bus;
  logic [7:0] rd_addr, wr_addr, wr_data, rd_data;
  logic       wr_stb, int_rst;

  int n_chk = 0;
  int n_fail = 0;
  int n_rstp = 0;
  logic [7:0] q_addr[$];
  logic [7:0] q_data[$];
  logic [7:0] regs [256];

  always #4 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;
  assign rd_data = regs[rd_addr];

  i2c_target #(.OWN_ADDR(OWN)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe),
    .rd_addr_o (rd_addr),
    .rd_data_i (rd_data),
    .wr_stb_o  (wr_stb),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .int_rst_o (int_rst)
  );

  // register file behind the port
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) regs[i] <= 8'h00;
    end else if (wr_stb) begin
      regs[wr_addr] <= wr_data;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // write-strobe monitor against the expected queue
  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      if (q_addr.size() == 0) begin
        check(1'b0, "R7 unexpected write", int'(wr_addr), -1);
      end else begin
        check(wr_addr == q_addr[0], "R7 write address", int'(wr_addr), int'(q_addr[0]));
        check(wr_data == q_data[0], "R7 write data", int'(wr_data), int'(q_data[0]));
        void'(q_addr.pop_front());
        void'(q_data.pop_front());
      end
    end
    if (rst_n && int_rst) n_rstp++;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one SCL clock; target output compared on every clock of the high phase
  task automatic bit_clk(input logic b, input logic exp_oe, input string tag);
    wait_n(8);
    sda_m = b;
    wait_n(8);
    scl_m = 1'b1;
    wait_n(5);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(sda_oe == exp_oe, tag, int'(sda_oe), int'(exp_oe));
    end
    wait_n(2);
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    wait_n(8);
    sda_m = 1'b1;
    wait_n(8);
    scl_m = 1'b1;
    wait_n(8);
    sda_m = 1'b0;
    wait_n(8);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    wait_n(8);
    sda_m = 1'b0;
    wait_n(8);
    scl_m = 1'b1;
    wait_n(8);
    sda_m = 1'b1;
    wait_n(16);
  endtask

  task automatic wbyte(input logic [7:0] b, input logic ack, input string tag);
    for (int i = 7; i >= 0; i--) bit_clk(b[i], 1'b0, tag);
    bit_clk(1'b1, ack, tag);
  endtask

  task automatic rbyte(input logic [7:0] exp, input logic mack, input string tag);
    for (int i = 7; i >= 0; i--) bit_clk(1'b1, ~exp[i], tag);
    bit_clk(~mack, 1'b0, tag);
  endtask

  task automatic expect_wr(input logic [7:0] a, input logic [7:0] d);
    q_addr.push_back(a);
    q_data.push_back(d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait_n(5);
    check(sda_oe == 1'b0, "R1 oe in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    wait_n(4);
    check(sda_oe == 1'b0, "R1 oe", int'(sda_oe), 0);
    check(wr_stb == 1'b0, "R1 strobe", int'(wr_stb), 0);
    check(int_rst == 1'b0, "R1 reset pulse", int'(int_rst), 0);
    check(rd_addr == 8'h00, "R1 pointer", int'(rd_addr), 0);

    // R5 R7: addressed write with pointer then two data bytes
    bus_start();
    wbyte(AW, 1'b1, "R5 own address ack");
    wbyte(8'h10, 1'b1, "R7 pointer byte ack");
    expect_wr(8'h10, 8'hA5);
    expect_wr(8'h11, 8'h3C);
    wbyte(8'hA5, 1'b1, "R7 data ack");
    wbyte(8'h3C, 1'b1, "R7 data ack");
    bus_stop();
    check(q_addr.size() == 0, "R7 writes done", q_addr.size(), 0);
    check(rd_addr == 8'h12, "R7 pointer increment", int'(rd_addr), 8'h12);

    // R3 R8 R9: pointer set, repeated START, read two bytes, master nack
    bus_start();
    wbyte(AW, 1'b1, "R5 own address ack");
    wbyte(8'h10, 1'b1, "R7 pointer byte ack");
    bus_start();
    wbyte(AR, 1'b1, "R3 read address after repeated start");
    rbyte(8'hA5, 1'b1, "R8 read byte 0");
    rbyte(8'h3C, 1'b0, "R8 read byte 1");
    bit_clk(1'b1, 1'b0, "R9 released after nack");
    bit_clk(1'b0, 1'b0, "R9 released after nack");
    bus_stop();
    check(rd_addr == 8'h12, "R8 pointer after read", int'(rd_addr), 8'h12);

    // R6: foreign address, following byte ignored
    bus_start();
    wbyte(8'h46, 1'b0, "R6 foreign address nack");
    wbyte(8'h55, 1'b0, "R6 ignored byte");
    wbyte(8'h77, 1'b0, "R6 ignored byte");
    bus_stop();
    check(rd_addr == 8'h12, "R6 pointer unchanged", int'(rd_addr), 8'h12);

    // R4: STOP right after pointer byte, then a fresh write to register 0
    bus_start();
    wbyte(AW, 1'b1, "R5 own address ack");
    wbyte(8'h20, 1'b1, "R7 pointer byte ack");
    bus_stop();
    check(sda_oe == 1'b0, "R4 released after stop", int'(sda_oe), 0);
    check(rd_addr == 8'h20, "R4 pointer kept", int'(rd_addr), 8'h20);
    bus_start();
    wbyte(AW, 1'b1, "R5 own address ack");
    wbyte(8'h00, 1'b1, "R7 pointer byte ack");
    expect_wr(8'h00, 8'h5A);
    wbyte(8'h5A, 1'b1, "R7 data ack");
    bus_stop();

    // R3: repeated START in the middle of a data byte
    bus_start();
    wbyte(AW, 1'b1, "R5 own address ack");
    wbyte(8'h40, 1'b1, "R7 pointer byte ack");
    for (int i = 0; i < 4; i++) bit_clk(1'b1, 1'b0, "R3 partial byte");
    bus_start();
    wbyte(AW, 1'b1, "R3 address after abort");
    wbyte(8'h50, 1'b1, "R3 pointer after abort");
    bus_stop();
    check(q_addr.size() == 0, "R3 no write from partial byte", q_addr.size(), 0);
    check(rd_addr == 8'h50, "R3 pointer from complete byte", int'(rd_addr), 8'h50);

    // R10: general call with another command, and general call read
    bus_start();
    wbyte(8'h00, 1'b1, "R10 general call ack");
    wbyte(8'h04, 1'b0, "R10 other command nack");
    bus_stop();
    bus_start();
    wbyte(8'h01, 1'b0, "R10 general call read nack");
    bus_stop();
    check(n_rstp == 0, "R10 no pulse", n_rstp, 0);
    check(rd_addr == 8'h50, "R10 pointer kept", int'(rd_addr), 8'h50);

    // R10: general call reset with a non-zero pointer
    bus_start();
    wbyte(8'h00, 1'b1, "R10 general call ack");
    wbyte(8'h06, 1'b1, "R10 reset command ack");
    bus_stop();
    check(n_rstp == 1, "R10 one reset pulse", n_rstp, 1);
    check(rd_addr == 8'h00, "R10 pointer cleared", int'(rd_addr), 0);
    bus_start();
    wbyte(AR, 1'b1, "R10 read after reset");
    rbyte(8'h5A, 1'b0, "R10 read register 0");
    bus_stop();
    check(q_addr.size() == 0, "R7 no stray writes", q_addr.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule